// File: doc/BRIEF.md
# Accumulator 24-bit Processor Core

This block is a small multi-cycle processor with 24-bit words. It runs a program held in a byte-wide synchronous memory. Every instruction is one 3-byte word. After the fetch the core forms the operand address, either directly from the instruction or with the index register added. It then loads, stores, does arithmetic, compares, branches, calls or returns, or moves one byte to or from a numbered device.

The memory port issues one byte read or one byte write per cycle. Read data is expected one cycle after the read strobe. A word access takes three consecutive byte accesses, least significant byte first. The device port carries a device number, which is the byte stored at the target address of the I/O instruction. It also carries a ready input, a read strobe with its data byte, and a write strobe with its data byte. The core raises its halt output on an undefined opcode or a division by zero, and holds it until reset.

Top module: `acc24_core`

## Requirements
- R1: While the synchronous reset `rst` is high and after it falls, A, X and L hold 0 and `halt` is low. The first cycle after reset issues a read of address 0.
- R2: An instruction is the 24-bit little-endian word at PC, PC+1, PC+2 (the byte at PC is bits 7:0). Bits 23:16 are the opcode, bit 15 is the index flag and bits 14:0 are the address field. PC advances by 3 after each fetch. Opcodes (hex): LDA 00, LDX 04, LDL 08, STA 0C, STX 10, STL 14, ADD 18, SUB 1C, MUL 20, DIV 24, COMP 28, TIX 2C, JEQ 30, JGT 34, JLT 38, J 3C, JSUB 48, RSUB 4C, LDCH 50, STCH 54, RD D8, WD DC, TD E0.
- R3: With the index flag at 0 the target address is the address field. With the flag at 1 it is the address field plus X, taken modulo 2^15.
- R4: LDA/LDX/LDL load a 3-byte little-endian word from the target address into A/X/L. STA/STX/STL store A/X/L the same way.
- R5: ADD, SUB and MUL combine A with the memory word and keep the low 24 bits of the two's complement result in A.
- R6: DIV sets A to the signed quotient, truncated toward zero. A zero divisor leaves A unchanged, raises halt and stops execution.
- R7: COMP compares A with the memory word as signed values and records less, equal or greater. JLT, JEQ and JGT load PC with the target only on a match. J always does.
- R8: JSUB stores the address of the following instruction in L and jumps to the target. RSUB loads PC from the low 15 bits of L.
- R9: LDCH replaces A[7:0] with the byte at the target and keeps A[23:8]. STCH writes A[7:0] to that single byte and touches no other byte.
- R10: TIX increments X and then compares the new X with the memory word, setting the condition as COMP does.
- R11: TD, RD and WD take the device number from the byte at the target address and drive it on `dev_num`. TD records less when `dev_ready` is high and equal when it is low. RD pulses `dev_rd` for one cycle and loads `dev_rdata` into A[7:0], keeping A[23:8]. WD pulses `dev_wr` for one cycle with `dev_wdata` equal to A[7:0].
- R12: An undefined opcode raises halt. Once high, halt stays high until reset, and the core drives no memory or device strobe. A read and a write are never issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 15 | Byte address for the read or write |
| mem_rd | output | 1 | Byte read request; data returned next cycle |
| mem_we | output | 1 | Byte write strobe |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid one cycle after mem_rd |
| dev_num | output | 8 | Number of the device addressed by TD, RD or WD |
| dev_ready | input | 1 | Addressed device can transfer a byte |
| dev_rdata | input | 8 | Byte offered by the device |
| dev_wdata | output | 8 | Byte sent to the device |
| dev_rd | output | 1 | One-cycle device read strobe |
| dev_wr | output | 1 | One-cycle device write strobe |
| halt | output | 1 | Core stopped |

## Verification
Each test targets a case that a plausible bug breaks. Signed compares use operands whose unsigned order is the reverse of their signed order, so an unsigned comparator takes the wrong branch. A negative dividend checks that division truncates toward zero rather than flooring. A division by zero must stop execution before the store that follows it. An indexed byte store is checked against its neighbouring bytes to catch writes that spill over. A device that stays not-ready for many cycles exercises the TD polling loop: a core that swapped the ready sense would never leave the loop, or would read before the device is ready. The LDCH and RD checks confirm that A keeps its upper 16 bits.

// File: rtl/acc24_pkg.sv
package acc24_pkg;

    localparam int WORD_W = 24;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 15;
    localparam int OP_W   = 8;
    localparam int FETCH_BYTES = WORD_W / BYTE_W;

    typedef enum logic [OP_W-1:0] {
        OP_LDA  = 8'h00, OP_LDX  = 8'h04, OP_LDL  = 8'h08,
        OP_STA  = 8'h0C, OP_STX  = 8'h10, OP_STL  = 8'h14,
        OP_ADD  = 8'h18, OP_SUB  = 8'h1C, OP_MUL  = 8'h20,
        OP_DIV  = 8'h24, OP_COMP = 8'h28, OP_TIX  = 8'h2C,
        OP_JEQ  = 8'h30, OP_JGT  = 8'h34, OP_JLT  = 8'h38,
        OP_J    = 8'h3C, OP_JSUB = 8'h48, OP_RSUB = 8'h4C,
        OP_LDCH = 8'h50, OP_STCH = 8'h54, OP_RD   = 8'hD8,
        OP_WD   = 8'hDC, OP_TD   = 8'hE0
    } op_e;

    typedef enum logic [1:0] {CC_LT = 2'd0, CC_EQ = 2'd1, CC_GT = 2'd2} cc_e;

    typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_MUL, ALU_DIV} alu_op_e;

    typedef enum logic [2:0] {
        S_FETCH, S_DECODE, S_LOAD, S_EXEC, S_STORE, S_HALT
    } state_e;

    typedef struct packed {
        state_e              state;
        logic [1:0]          cnt;
        logic [1:0]          len;
        logic [ADDR_W-1:0]   pc;
        logic [WORD_W-1:0]   a;
        logic [WORD_W-1:0]   x;
        logic [WORD_W-1:0]   l;
        cc_e                 cc;
        logic [WORD_W-1:0]   ir;
        logic [ADDR_W-1:0]   ta;
        logic [WORD_W-1:0]   opnd;
    } core_s;

    function automatic logic [WORD_W-1:0] put_byte(input logic [WORD_W-1:0] w,
                                                   input logic [1:0] idx,
                                                   input logic [BYTE_W-1:0] b);
        logic [WORD_W-1:0] r;
        r = w;
        case (idx)
            2'd0:    r[7:0]   = b;
            2'd1:    r[15:8]  = b;
            default: r[23:16] = b;
        endcase
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] get_byte(input logic [WORD_W-1:0] w,
                                                   input logic [1:0] idx);
        case (idx)
            2'd0:    return w[7:0];
            2'd1:    return w[15:8];
            default: return w[23:16];
        endcase
    endfunction

endpackage

// File: rtl/acc24_agen.sv
module acc24_agen
    import acc24_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] field,
    input  logic          idx_en,
    input  logic [AW-1:0] xreg,
    output logic [AW-1:0] ta
);
    logic [AW-1:0] offs;

    always_comb begin
        offs = idx_en ? xreg : '0;
        ta   = field + offs;
    end
endmodule

// File: rtl/acc24_alu.sv
module acc24_alu
    import acc24_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   lhs,
    input  logic [W-1:0]   rhs,
    output logic [W-1:0]   res,
    output logic           div_zero,
    output cc_e            rel
);
    logic [W-1:0] divisor;
    logic [W-1:0] quot;

    always_comb begin
        div_zero = (rhs == '0);
        divisor  = div_zero ? W'(1) : rhs;
        quot     = W'($signed(lhs) / $signed(divisor));
        case (op)
            ALU_ADD: res = lhs + rhs;
            ALU_SUB: res = lhs - rhs;
            ALU_MUL: res = lhs * rhs;
            default: res = div_zero ? lhs : quot;
        endcase
        if ($signed(lhs) < $signed(rhs))
            rel = CC_LT;
        else if (lhs == rhs)
            rel = CC_EQ;
        else
            rel = CC_GT;
    end
endmodule

// File: rtl/acc24_core.sv
module acc24_core
    import acc24_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [BYTE_W-1:0] dev_num,
    input  logic              dev_ready,
    input  logic [BYTE_W-1:0] dev_rdata,
    output logic [BYTE_W-1:0] dev_wdata,
    output logic              dev_rd,
    output logic              dev_wr,
    output logic              halt
);
    localparam logic [1:0] FETCH_LEN = 2'(FETCH_BYTES);
    localparam logic [1:0] WORD_LEN  = 2'(FETCH_BYTES);
    localparam logic [1:0] BYTE_LEN  = 2'd1;

    core_s core_q, core_d;

    logic [OP_W-1:0]   opc;
    logic [ADDR_W-1:0] ta_w;
    logic [WORD_W-1:0] alu_lhs, alu_res, x_inc;
    logic              alu_dz;
    cc_e               alu_rel;
    alu_op_e           alu_op;

    assign opc   = core_q.ir[WORD_W-1 -: OP_W];
    assign x_inc = core_q.x + WORD_W'(1);

    acc24_agen #(.AW(ADDR_W)) u_agen (
        .field  (core_q.ir[ADDR_W-1:0]),
        .idx_en (core_q.ir[ADDR_W]),
        .xreg   (core_q.x[ADDR_W-1:0]),
        .ta     (ta_w)
    );

    always_comb begin
        case (opc)
            OP_SUB:  alu_op = ALU_SUB;
            OP_MUL:  alu_op = ALU_MUL;
            OP_DIV:  alu_op = ALU_DIV;
            default: alu_op = ALU_ADD;
        endcase
        alu_lhs = (opc == OP_TIX) ? x_inc : core_q.a;
    end

    acc24_alu #(.W(WORD_W)) u_alu (
        .op       (alu_op),
        .lhs      (alu_lhs),
        .rhs      (core_q.opnd),
        .res      (alu_res),
        .div_zero (alu_dz),
        .rel      (alu_rel)
    );

    assign dev_num   = core_q.opnd[BYTE_W-1:0];
    assign dev_wdata = core_q.a[BYTE_W-1:0];
    assign halt      = (core_q.state == S_HALT);

    always_comb begin
        core_d    = core_q;
        mem_addr  = core_q.pc;
        mem_rd    = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        dev_rd    = 1'b0;
        dev_wr    = 1'b0;

        case (core_q.state)
            S_FETCH: begin
                mem_addr = core_q.pc + ADDR_W'(core_q.cnt);
                mem_rd   = (core_q.cnt < FETCH_LEN);
                if (core_q.cnt != 2'd0)
                    core_d.ir = put_byte(core_q.ir, core_q.cnt - 2'd1, mem_rdata);
                if (core_q.cnt == FETCH_LEN) begin
                    core_d.cnt   = 2'd0;
                    core_d.pc    = core_q.pc + ADDR_W'(FETCH_BYTES);
                    core_d.state = S_DECODE;
                end else begin
                    core_d.cnt = core_q.cnt + 2'd1;
                end
            end

            S_DECODE: begin
                core_d.ta    = ta_w;
                core_d.cnt   = 2'd0;
                core_d.opnd  = '0;
                core_d.state = S_FETCH;
                case (opc)
                    OP_J:    core_d.pc = ta_w;
                    OP_JEQ:  if (core_q.cc == CC_EQ) core_d.pc = ta_w;
                    OP_JGT:  if (core_q.cc == CC_GT) core_d.pc = ta_w;
                    OP_JLT:  if (core_q.cc == CC_LT) core_d.pc = ta_w;
                    OP_JSUB: begin
                        core_d.l  = {{(WORD_W-ADDR_W){1'b0}}, core_q.pc};
                        core_d.pc = ta_w;
                    end
                    OP_RSUB: core_d.pc = core_q.l[ADDR_W-1:0];
                    OP_STA: begin
                        core_d.opnd = core_q.a; core_d.len = WORD_LEN; core_d.state = S_STORE;
                    end
                    OP_STX: begin
                        core_d.opnd = core_q.x; core_d.len = WORD_LEN; core_d.state = S_STORE;
                    end
                    OP_STL: begin
                        core_d.opnd = core_q.l; core_d.len = WORD_LEN; core_d.state = S_STORE;
                    end
                    OP_STCH: begin
                        core_d.opnd = core_q.a; core_d.len = BYTE_LEN; core_d.state = S_STORE;
                    end
                    OP_LDA, OP_LDX, OP_LDL, OP_ADD, OP_SUB, OP_MUL, OP_DIV,
                    OP_COMP, OP_TIX: begin
                        core_d.len = WORD_LEN; core_d.state = S_LOAD;
                    end
                    OP_LDCH, OP_RD, OP_WD, OP_TD: begin
                        core_d.len = BYTE_LEN; core_d.state = S_LOAD;
                    end
                    default: core_d.state = S_HALT;
                endcase
            end

            S_LOAD: begin
                mem_addr = core_q.ta + ADDR_W'(core_q.cnt);
                mem_rd   = (core_q.cnt < core_q.len);
                if (core_q.cnt != 2'd0)
                    core_d.opnd = put_byte(core_q.opnd, core_q.cnt - 2'd1, mem_rdata);
                if (core_q.cnt == core_q.len) begin
                    core_d.cnt   = 2'd0;
                    core_d.state = S_EXEC;
                end else begin
                    core_d.cnt = core_q.cnt + 2'd1;
                end
            end

            S_EXEC: begin
                core_d.state = S_FETCH;
                case (opc)
                    OP_LDA:  core_d.a = core_q.opnd;
                    OP_LDX:  core_d.x = core_q.opnd;
                    OP_LDL:  core_d.l = core_q.opnd;
                    OP_ADD, OP_SUB, OP_MUL: core_d.a = alu_res;
                    OP_DIV: begin
                        if (alu_dz) core_d.state = S_HALT;
                        else        core_d.a = alu_res;
                    end
                    OP_COMP: core_d.cc = alu_rel;
                    OP_TIX: begin
                        core_d.x  = x_inc;
                        core_d.cc = alu_rel;
                    end
                    OP_LDCH: core_d.a[BYTE_W-1:0] = core_q.opnd[BYTE_W-1:0];
                    OP_TD:   core_d.cc = dev_ready ? CC_LT : CC_EQ;
                    OP_RD: begin
                        dev_rd = 1'b1;
                        core_d.a[BYTE_W-1:0] = dev_rdata;
                    end
                    OP_WD:   dev_wr = 1'b1;
                    default: core_d.state = S_HALT;
                endcase
            end

            S_STORE: begin
                mem_addr  = core_q.ta + ADDR_W'(core_q.cnt);
                mem_we    = 1'b1;
                mem_wdata = get_byte(core_q.opnd, core_q.cnt);
                if (core_q.cnt == core_q.len - 2'd1) begin
                    core_d.cnt   = 2'd0;
                    core_d.state = S_FETCH;
                end else begin
                    core_d.cnt = core_q.cnt + 2'd1;
                end
            end

            default: core_d.state = S_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_q       <= '0;
            core_q.state <= S_FETCH;
            core_q.pc    <= RESET_PC;
            core_q.cc    <= CC_EQ;
        end else begin
            core_q <= core_d;
        end
    end

    // R12: a stopped core stays stopped
    p_halt_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        halt |=> halt);

    // R12: no traffic on either port once stopped
    p_halt_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        halt |-> !(mem_rd || mem_we || dev_rd || dev_wr));

    // R12: one memory direction per cycle
    p_mem_excl_r12: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_we));

    // R11: device strobes never overlap
    p_dev_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(dev_rd && dev_wr));

    // R2: completing a fetch moves PC past the instruction
    p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
        (core_q.state == S_FETCH && core_q.cnt == FETCH_LEN)
        |=> (core_q.pc == $past(core_q.pc) + ADDR_W'(FETCH_BYTES)));

    // R11: a device strobe only follows a completed byte load
    p_dev_after_load_r11: assert property (@(posedge clk) disable iff (rst)
        (dev_rd || dev_wr) |-> ($past(core_q.state) == S_LOAD));
endmodule

// File: tb/tb_acc24_core.sv
`timescale 1ns/1ps
module tb_acc24_core;
    localparam int MEM_SZ = 4096;
    localparam logic [7:0] HLT = 8'hFF;
    localparam logic [7:0] LDA = 8'h00, LDX = 8'h04, LDL = 8'h08, STA = 8'h0C,
        STX = 8'h10, STL = 8'h14, ADD = 8'h18, SUB = 8'h1C, MUL = 8'h20,
        DIV = 8'h24, COMP = 8'h28, TIX = 8'h2C, JEQ = 8'h30, JGT = 8'h34,
        JLT = 8'h38, JMP = 8'h3C, JSUB = 8'h48, RSUB = 8'h4C, LDCH = 8'h50,
        STCH = 8'h54, RDD = 8'hD8, WRD = 8'hDC, TDV = 8'hE0;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst = 1'b1;
    logic [14:0] mem_addr;
    logic        mem_rd, mem_we, dev_ready, dev_rd, dev_wr, halt;
    logic [7:0]  mem_wdata, mem_rdata, dev_num, dev_wdata;
    logic [7:0]  dev_rdata = 8'h3C;

    logic [7:0] mem [0:MEM_SZ-1];
    int checks = 0, errors = 0;
    int wr_cnt = 0, drd_cnt = 0, dwr_cnt = 0, cyc = 0;
    logic [7:0] drd_num, dwr_num, dwr_data;
    logic       rdy_en = 1'b0;
    logic [7:0] rdy_id = 8'h05;
    int         rdy_after = 0;

    acc24_core dut (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .dev_num(dev_num), .dev_ready(dev_ready), .dev_rdata(dev_rdata),
        .dev_wdata(dev_wdata), .dev_rd(dev_rd), .dev_wr(dev_wr), .halt(halt)
    );

    assign dev_ready = rdy_en && (dev_num == rdy_id) && (cyc >= rdy_after);

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr[11:0]] = mem_wdata;
            wr_cnt++;
        end
        if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];
        if (rst) begin
            cyc = 0; drd_cnt = 0; dwr_cnt = 0;
        end else begin
            cyc++;
            if (dev_rd) begin drd_cnt++; drd_num = dev_num; end
            if (dev_wr) begin dwr_cnt++; dwr_num = dev_num; dwr_data = dev_wdata; end
        end
    end

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < MEM_SZ; i++) mem[i] = 8'hFF;
        rdy_en = 1'b0; rdy_after = 0;
    endtask

    task automatic put_ins(input int a, input logic [7:0] op, input logic ix, input logic [14:0] f);
        mem[a] = f[7:0]; mem[a+1] = {ix, f[14:8]}; mem[a+2] = op;
    endtask

    task automatic put_word(input int a, input logic [23:0] w);
        mem[a] = w[7:0]; mem[a+1] = w[15:8]; mem[a+2] = w[23:16];
    endtask

    function automatic logic [23:0] word_at(input int a);
        return {mem[a+2], mem[a+1], mem[a]};
    endfunction

    task automatic run_prog(input string req);
        bit done;
        done = 0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 20000 && !done; i++) begin
            @(negedge clk);
            if (halt) done = 1;
        end
        check({req, " halt reached"}, {23'd0, halt}, 24'd1);
    endtask

    task automatic t_reset();
        clear_mem();
        put_ins(0, STA, 0, 15'h300);
        put_ins(3, STX, 0, 15'h303);
        put_ins(6, STL, 0, 15'h306);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 halt low in reset", {23'd0, halt}, 24'd0);
        check("R1 no write in reset", {23'd0, mem_we}, 24'd0);
        rst = 1'b0;
        #1;
        check("R1 first read strobe", {23'd0, mem_rd}, 24'd1);
        check("R1 first read address", {9'd0, mem_addr}, 24'd0);
        for (int i = 0; i < 200 && !halt; i++) @(negedge clk);
        check("R1 A after reset", word_at(12'h300), 24'd0);
        check("R1 X after reset", word_at(12'h303), 24'd0);
        check("R1 L after reset", word_at(12'h306), 24'd0);
    endtask

    task automatic t_arith();
        clear_mem();
        put_ins(0, LDA, 0, 15'h200); put_ins(3, ADD, 0, 15'h203);
        put_ins(6, SUB, 0, 15'h206); put_ins(9, MUL, 0, 15'h209);
        put_ins(12, STA, 0, 15'h300); put_ins(15, LDX, 0, 15'h20C);
        put_ins(18, STX, 0, 15'h303); put_ins(21, LDL, 0, 15'h20F);
        put_ins(24, STL, 0, 15'h306); put_ins(27, LDA, 0, 15'h212);
        put_ins(30, MUL, 0, 15'h215); put_ins(33, STA, 0, 15'h309);
        put_word(12'h200, 24'd5); put_word(12'h203, 24'hFFFFFE);
        put_word(12'h206, 24'd10); put_word(12'h209, 24'd3);
        put_word(12'h20C, 24'h000123); put_word(12'h20F, 24'h7A5A3C);
        put_word(12'h212, 24'h400000); put_word(12'h215, 24'd4);
        run_prog("R5");
        check("R5 add sub mul result", word_at(12'h300), 24'hFFFFEB);
        check("R4 low byte first", {16'd0, mem[12'h300]}, 24'h0000EB);
        check("R4 X load store", word_at(12'h303), 24'h000123);
        check("R4 L load store", word_at(12'h306), 24'h7A5A3C);
        check("R5 product wraps", word_at(12'h309), 24'd0);
    endtask

    task automatic t_div();
        clear_mem();
        put_ins(0, LDA, 0, 15'h200); put_ins(3, DIV, 0, 15'h203);
        put_ins(6, STA, 0, 15'h300); put_ins(9, LDA, 0, 15'h206);
        put_ins(12, DIV, 0, 15'h209); put_ins(15, STA, 0, 15'h303);
        put_word(12'h200, 24'hFFFFEB); put_word(12'h203, 24'd4);
        put_word(12'h206, 24'd7); put_word(12'h209, 24'd0);
        put_word(12'h303, 24'h111111);
        run_prog("R6");
        check("R6 signed quotient", word_at(12'h300), 24'hFFFFFB);
        check("R6 no store after zero divisor", word_at(12'h303), 24'h111111);
    endtask

    task automatic t_cmp(input logic [23:0] va, input logic [23:0] vb, input logic [23:0] exp);
        clear_mem();
        put_ins(0, LDA, 0, 15'h200); put_ins(3, COMP, 0, 15'h203);
        put_ins(6, JLT, 0, 15'h030); put_ins(9, JEQ, 0, 15'h040);
        put_ins(12, JGT, 0, 15'h050); put_ins(15, LDA, 0, 15'h20C);
        put_ins(18, STA, 0, 15'h300);
        put_ins(12'h30, LDA, 0, 15'h206); put_ins(12'h33, STA, 0, 15'h300);
        put_ins(12'h40, LDA, 0, 15'h209); put_ins(12'h43, STA, 0, 15'h300);
        put_ins(12'h50, LDA, 0, 15'h20F); put_ins(12'h53, STA, 0, 15'h300);
        put_word(12'h200, va); put_word(12'h203, vb);
        put_word(12'h206, 24'd1); put_word(12'h209, 24'd2);
        put_word(12'h20F, 24'd3); put_word(12'h20C, 24'd9);
        run_prog("R7");
        check("R7 branch taken after compare", word_at(12'h300), exp);
    endtask

    task automatic t_sub();
        clear_mem();
        put_ins(0, JSUB, 0, 15'h100); put_ins(3, STA, 0, 15'h300);
        put_ins(6, JMP, 0, 15'h080);
        put_ins(12'h80, LDA, 0, 15'h203); put_ins(12'h83, STA, 0, 15'h306);
        put_ins(12'h100, LDA, 0, 15'h200); put_ins(12'h103, STL, 0, 15'h303);
        put_ins(12'h106, RSUB, 0, 15'h000);
        put_word(12'h200, 24'h123456); put_word(12'h203, 24'h0000AA);
        run_prog("R8");
        check("R8 return resumes after call", word_at(12'h300), 24'h123456);
        check("R8 link holds return address", word_at(12'h303), 24'd3);
        check("R7 unconditional jump", word_at(12'h306), 24'h0000AA);
    endtask

    task automatic t_bytes();
        clear_mem();
        put_ins(0, LDX, 0, 15'h200); put_ins(3, LDA, 0, 15'h203);
        put_ins(6, LDCH, 1, 15'h210); put_ins(9, STA, 0, 15'h300);
        put_ins(12, STCH, 1, 15'h310);
        put_word(12'h200, 24'd2); put_word(12'h203, 24'hABCDEF);
        mem[12'h210] = 8'h11; mem[12'h211] = 8'h22; mem[12'h212] = 8'h5A;
        run_prog("R9");
        check("R9 R3 indexed byte load keeps upper A", word_at(12'h300), 24'hABCD5A);
        check("R9 R3 indexed byte store", {16'd0, mem[12'h312]}, 24'h00005A);
        check("R9 byte below untouched", {16'd0, mem[12'h311]}, 24'h0000FF);
        check("R9 byte above untouched", {16'd0, mem[12'h313]}, 24'h0000FF);
    endtask

    task automatic t_tix();
        clear_mem();
        put_ins(0, LDX, 0, 15'h200); put_ins(3, LDCH, 1, 15'h210);
        put_ins(6, STCH, 1, 15'h310); put_ins(9, TIX, 0, 15'h203);
        put_ins(12, JLT, 0, 15'h003); put_ins(15, STX, 0, 15'h300);
        put_word(12'h200, 24'd0); put_word(12'h203, 24'd4);
        mem[12'h210] = 8'h10; mem[12'h211] = 8'h20;
        mem[12'h212] = 8'h30; mem[12'h213] = 8'h40;
        run_prog("R10");
        check("R10 loop copied bytes", {mem[12'h310], mem[12'h311], mem[12'h313]}, 24'h102040);
        check("R10 third byte copied", {16'd0, mem[12'h312]}, 24'h000030);
        check("R10 loop stops at limit", {16'd0, mem[12'h314]}, 24'h0000FF);
        check("R10 final index", word_at(12'h300), 24'd4);
    endtask

    task automatic t_dev_test(input logic ready, input logic [23:0] exp);
        clear_mem();
        put_ins(0, TDV, 0, 15'h200); put_ins(3, JEQ, 0, 15'h030);
        put_ins(6, JLT, 0, 15'h040);
        put_ins(12'h30, LDA, 0, 15'h203); put_ins(12'h33, STA, 0, 15'h300);
        put_ins(12'h40, LDA, 0, 15'h206); put_ins(12'h43, STA, 0, 15'h300);
        mem[12'h200] = 8'h05;
        put_word(12'h203, 24'd1); put_word(12'h206, 24'd2);
        rdy_en = ready; rdy_id = 8'h05;
        run_prog("R11");
        check("R11 device test sets condition", word_at(12'h300), exp);
    endtask

    task automatic t_dev_io();
        clear_mem();
        put_ins(0, LDA, 0, 15'h204); put_ins(3, TDV, 0, 15'h200);
        put_ins(6, JEQ, 0, 15'h003); put_ins(9, RDD, 0, 15'h200);
        put_ins(12, STA, 0, 15'h300); put_ins(15, WRD, 0, 15'h201);
        mem[12'h200] = 8'h05; mem[12'h201] = 8'h08;
        put_word(12'h204, 24'hC0FFEE);
        rdy_en = 1'b1; rdy_id = 8'h05; rdy_after = 60;
        run_prog("R11");
        check("R11 read byte into low A", word_at(12'h300), 24'hC0FF3C);
        check("R11 one read strobe", 24'(drd_cnt), 24'd1);
        check("R11 read device number", {16'd0, drd_num}, 24'h000005);
        check("R11 one write strobe", 24'(dwr_cnt), 24'd1);
        check("R11 write device and data", {8'd0, dwr_num, dwr_data}, 24'h00083C);
    endtask

    task automatic t_undef();
        int w0;
        clear_mem();
        put_ins(0, LDA, 0, 15'h200); put_ins(3, 8'h44, 0, 15'h000);
        put_ins(6, STA, 0, 15'h300);
        put_word(12'h200, 24'h000042);
        run_prog("R12");
        w0 = wr_cnt;
        repeat (20) @(negedge clk);
        check("R12 halt held", {23'd0, halt}, 24'd1);
        check("R12 no writes while halted", 24'(wr_cnt - w0), 24'd0);
        check("R12 instruction after undefined skipped", word_at(12'h300), 24'hFFFFFF);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_arith();
        t_div();
        t_cmp(24'hFFFFFF, 24'd1, 24'd1);
        t_cmp(24'd5, 24'd5, 24'd2);
        t_cmp(24'd7, 24'd2, 24'd3);
        t_cmp(24'd1, 24'hFFFFFF, 24'd3);
        t_sub();
        t_bytes();
        t_tix();
        t_dev_test(1'b0, 24'd1);
        t_dev_test(1'b1, 24'd2);
        t_dev_io();
        t_undef();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule